// File: doc/BRIEF.md
# Capture-Compare General-Purpose Timer

This block is a 16-bit up-counter with an 8-bit prescaler and a choice of four count sources. The sources are stopped, the system clock, the system clock divided by sixteen, and falling edges on an external input pin. Each time the counter advances to the value held in a reference register, the block raises a reference event. That event either drives the output pin low for one cycle or toggles it. The counter then either keeps running or starts again from zero.

The same input pin also feeds a capture path. On a chosen edge of the pin, the current count is copied into a read-only capture register and a capture event is raised. The interrupt line is the OR of the two event flags, each gated by its own enable. Software clears the event flags by writing ones to them.

Software reaches the timer through a plain register port. Writes take one cycle and reads are combinational. The port has no valid/ready handshake, because every access completes at once and nothing can stall it. Clearing the enable bit of the mode register holds the timer in reset. A write that takes that bit from 1 to 0 also returns the other registers to their reset values.

Top module: `gpt_capcmp`

## Requirements
- R1: The prescaler field (mode bits 15:8, value P) passes one count tick for every P+1 pulses of the selected source. P=0 divides by 1 and P=255 divides by 256.
- R2: The clock select field (mode bits 2:1) chooses the count source:
  - 00: no count.
  - 01: every system clock.
  - 10: one pulse every 16 system clocks.
  - 11: each falling edge of the synchronised input pin.
- R3: The output pin is high after reset and while the timer is disabled. Mode bit 5 sets how a match affects it:
  - Bit 5 = 0: a match drives the pin low for exactly the one cycle after the match. It stays low only if another match follows at once.
  - Bit 5 = 1: each match inverts the pin.
- R4: The interrupt output is (reference flag AND mode bit 4) OR (capture flag AND capture field not 00).
- R5: With mode bit 3 = 0 the counter free-runs and wraps from 0xFFFF to 0. With bit 3 = 1, the tick after the counter has reached the reference loads the counter with 0.
- R6: A match is declared on a count tick whose new counter value equals the reference register. A match sets the reference flag.
- R7: Mode bit 0 enables the timer. While it is 0, the counter, the prescaler and the divide-by-16 stage are held at 0, and no capture occurs. Mode and reference writes still take effect. A mode write that changes bit 0 from 1 to 0 sets the reference register to 0xFFFF, clears the capture register, the counter and both flags, and sets the output high.
- R8: After hardware reset the register values are: mode 0, reference 0xFFFF, capture 0, counter 0, event 0.
- R9: The input pin passes through a two-flop synchroniser, and edges are found from the synchronised value. The capture field (mode bits 7:6) selects the edge:
  - 00: no capture.
  - 01: rising edge.
  - 10: falling edge.
  - 11: either edge.
  On a selected edge, the capture register takes the counter value of that cycle and the capture flag is set.
- R10: The event register (address 4) holds the capture flag in bit 0 and the reference flag in bit 1. Writing a 1 to a bit clears that flag. A hardware set in the same cycle as a clear leaves the flag set.
- R11: The register addresses are: 0 mode, 1 reference, 2 capture (read-only), 3 counter, 4 event. Any other address reads 0. A counter write loads the written value while the timer is enabled, and it takes priority over a tick in the same cycle. Read data follows the read address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Write address |
| reg_wdata | input | 16 | Write data |
| reg_raddr | input | 3 | Read address |
| reg_rdata | output | 16 | Read data, combinational |
| tmr_in | input | 1 | External pin: capture input and external count source |
| tmr_out | output | 1 | Compare output pin |
| tmr_irq | output | 1 | Interrupt request |

## Verification
The collision that matters most is a hardware event setting a flag in the same cycle that software writes a one to clear it. The bench provokes it by running the counter in restart mode with a short reference, so matches recur every few cycles. It then issues clear writes at stepped offsets until some of them land on a match cycle. A capture can also fall on the cycle of a counter write or a soft reset; the bench drives pin toggles across those writes.

In every case a behavioural model decides which action wins. The bench compares the flags, the interrupt and the counter with that model on every clock.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int CNT_W  = 16;
  localparam int PS_W   = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] A_REF  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CAPT = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_EVT  = 3'd4;

  typedef enum logic [1:0] {
    SRC_OFF  = 2'b00,
    SRC_SYS  = 2'b01,
    SRC_D16  = 2'b10,
    SRC_PIN  = 2'b11
  } gpt_src_e;

  typedef struct packed {
    logic [PS_W-1:0] presc;
    logic [1:0]      cap_sel;
    logic            out_tgl;
    logic            ref_ie;
    logic            restart;
    gpt_src_e        src;
    logic            en;
  } gpt_mode_t;
endpackage

// File: rtl/gpt_edge_sync.sv
module gpt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              dly;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dly <= 1'b0;
    else        dly <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~dly;
  assign fall = ~chain[STAGES-1] & dly;
endmodule

// File: rtl/gpt_tick_gen.sv
module gpt_tick_gen
  import gpt_pkg::*;
#(
  parameter int PW    = PS_W,
  parameter int DIV_N = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  gpt_src_e      src,
  input  logic [PW-1:0] presc,
  input  logic          pin_fall,
  output logic          tick
);
  localparam int DW = $clog2(DIV_N);
  localparam logic [DW-1:0] DLAST = DW'(DIV_N - 1);

  logic [DW-1:0] div_q;
  logic [PW-1:0] pc_q;
  logic          src_pulse;
  logic          pc_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   div_q <= '0;
    else if (!en) div_q <= '0;
    else          div_q <= (div_q == DLAST) ? '0 : div_q + 1'b1;
  end

  always_comb begin
    unique case (src)
      SRC_SYS: src_pulse = 1'b1;
      SRC_D16: src_pulse = (div_q == DLAST);
      SRC_PIN: src_pulse = pin_fall;
      default: src_pulse = 1'b0;
    endcase
  end

  assign pc_full = (pc_q >= presc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pc_q <= '0;
    else if (!en)       pc_q <= '0;
    else if (src_pulse) pc_q <= pc_full ? '0 : pc_q + 1'b1;
  end

  assign tick = en & src_pulse & pc_full;

  AST_TICK_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && src == SRC_OFF) |-> 1'b0) else $error("tick with source off"); // R2
endmodule

// File: rtl/gpt_count_core.sv
module gpt_count_core
  import gpt_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic          restart,
  input  logic [CW-1:0] ref_val,
  input  logic          ld,
  input  logic [CW-1:0] ld_val,
  input  logic          clr,
  output logic [CW-1:0] cnt,
  output logic          match
);
  logic [CW-1:0] nxt;
  logic          at_ref;

  assign at_ref = (cnt == ref_val);
  assign nxt    = (restart && at_ref) ? '0 : cnt + 1'b1;
  assign match  = tick & ~ld & ~clr & (nxt == ref_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr || !en) cnt <= '0;
    else if (ld)         cnt <= ld_val;
    else if (tick)       cnt <= nxt;
  end

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && restart && at_ref && !ld && !clr) |=> (cnt == '0))
    else $error("restart did not zero counter"); // R5
  AST_CNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> (cnt == '0)) else $error("counter moved while disabled"); // R7
endmodule

// File: rtl/gpt_capcmp.sv
module gpt_capcmp
  import gpt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_waddr,
  input  logic [15:0] reg_wdata,
  input  logic [2:0]  reg_raddr,
  output logic [15:0] reg_rdata,
  input  logic        tmr_in,
  output logic        tmr_out,
  output logic        tmr_irq
);
  gpt_mode_t         mode_q;
  logic [CNT_W-1:0]  ref_q;
  logic [CNT_W-1:0]  capt_q;
  logic [1:0]        evt_q;
  logic              out_q;
  logic [CNT_W-1:0]  cnt;
  logic              match;
  logic              tick;
  logic              pin_rise, pin_fall;
  logic              cap_hit;
  logic              wr_mode, wr_ref, wr_cnt, wr_evt;
  logic              soft_rst;
  logic [1:0]        evt_clr;

  assign wr_mode  = reg_wr && (reg_waddr == A_MODE);
  assign wr_ref   = reg_wr && (reg_waddr == A_REF);
  assign wr_cnt   = reg_wr && (reg_waddr == A_CNT);
  assign wr_evt   = reg_wr && (reg_waddr == A_EVT);
  assign soft_rst = wr_mode && mode_q.en && !reg_wdata[0];
  assign evt_clr  = wr_evt ? reg_wdata[1:0] : 2'b00;

  gpt_edge_sync #(.STAGES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (tmr_in),
    .rise (pin_rise),
    .fall (pin_fall)
  );

  gpt_tick_gen #(.PW(PS_W), .DIV_N(16)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (mode_q.en),
    .src     (mode_q.src),
    .presc   (mode_q.presc),
    .pin_fall(pin_fall),
    .tick    (tick)
  );

  gpt_count_core #(.CW(CNT_W)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (mode_q.en),
    .tick   (tick),
    .restart(mode_q.restart),
    .ref_val(ref_q),
    .ld     (wr_cnt),
    .ld_val (reg_wdata),
    .clr    (soft_rst),
    .cnt    (cnt),
    .match  (match)
  );

  always_comb begin
    unique case (mode_q.cap_sel)
      2'b01:   cap_hit = pin_rise;
      2'b10:   cap_hit = pin_fall;
      2'b11:   cap_hit = pin_rise | pin_fall;
      default: cap_hit = 1'b0;
    endcase
    cap_hit = cap_hit & mode_q.en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (wr_mode) mode_q <= gpt_mode_t'(reg_wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ref_q <= '1;
    else if (soft_rst) ref_q <= '1;
    else if (wr_ref)   ref_q <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        capt_q <= '0;
    else if (soft_rst) capt_q <= '0;
    else if (cap_hit)  capt_q <= cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        evt_q <= '0;
    else if (soft_rst) evt_q <= '0;
    else               evt_q <= (evt_q & ~evt_clr) | {match, cap_hit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      out_q <= 1'b1;
    else if (soft_rst || !mode_q.en) out_q <= 1'b1;
    else if (match)                  out_q <= mode_q.out_tgl ? ~out_q : 1'b0;
    else if (!mode_q.out_tgl)        out_q <= 1'b1;
  end

  always_comb begin
    unique case (reg_raddr)
      A_MODE:  reg_rdata = mode_q;
      A_REF:   reg_rdata = ref_q;
      A_CAPT:  reg_rdata = capt_q;
      A_CNT:   reg_rdata = cnt;
      A_EVT:   reg_rdata = {14'd0, evt_q};
      default: reg_rdata = '0;
    endcase
  end

  assign tmr_out = out_q;
  assign tmr_irq = (evt_q[1] & mode_q.ref_ie) | (evt_q[0] & |mode_q.cap_sel);

  AST_OUT_FALL_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_q) |-> $past(match)) else $error("output fell without match"); // R3
  AST_SOFT_RST_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (ref_q == 16'hFFFF && cnt == '0 && capt_q == '0 && evt_q == 2'b00 && out_q))
    else $error("soft reset values wrong"); // R7
  AST_CAP_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_hit && !soft_rst) |=> (capt_q == $past(cnt) && evt_q[0]))
    else $error("capture did not latch"); // R9
  AST_MATCH_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !soft_rst) |=> evt_q[1]) else $error("match flag lost"); // R10
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_irq |-> (evt_q != 2'b00)) else $error("irq without flag"); // R4
endmodule

// File: tb/gpt_capcmp_tb.sv
module gpt_capcmp_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_waddr = 3'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [2:0]  reg_raddr = 3'd0;
  logic [15:0] reg_rdata;
  logic        tmr_in = 1'b0;
  logic        tmr_out;
  logic        tmr_irq;

  int    n_checks = 0;
  int    n_errors = 0;
  int    cycles = 0;
  bit    done = 1'b0;
  string phase = "R8";

  gpt_capcmp dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .tmr_in(tmr_in), .tmr_out(tmr_out), .tmr_irq(tmr_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference state
  int m_mode, m_ref, m_cap, m_cnt, m_ev, m_out, m_div, m_pc;
  int m_s1, m_s2, m_s3;
  int t_en, t_sel, t_ps, t_cs, t_tg, t_rs, t_rise, t_fall, t_src, t_tick;
  int t_wm, t_wr, t_wc, t_we, t_srst, t_nxt, t_match, t_cap, t_clr;

  function automatic int model_read(input int a);
    case (a)
      0: return m_mode;
      1: return m_ref;
      2: return m_cap;
      3: return m_cnt;
      4: return m_ev;
      default: return 0;
    endcase
  endfunction

  function automatic int model_irq();
    return (((m_ev >> 1) & 1) & ((m_mode >> 4) & 1)) |
           ((m_ev & 1) & ((((m_mode >> 6) & 3) != 0) ? 1 : 0));
  endfunction

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_ref = 16'hFFFF; m_cap = 0; m_cnt = 0; m_ev = 0; m_out = 1;
      m_div = 0; m_pc = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      t_en = m_mode & 1; t_sel = (m_mode >> 1) & 3; t_ps = (m_mode >> 8) & 255;
      t_cs = (m_mode >> 6) & 3; t_tg = (m_mode >> 5) & 1; t_rs = (m_mode >> 3) & 1;
      t_rise = (m_s2 == 1 && m_s3 == 0) ? 1 : 0;
      t_fall = (m_s2 == 0 && m_s3 == 1) ? 1 : 0;
      t_src = (t_sel == 1) ? 1 : (t_sel == 2) ? ((m_div == 15) ? 1 : 0) : (t_sel == 3) ? t_fall : 0;
      t_tick = (t_en == 1 && t_src == 1 && m_pc >= t_ps) ? 1 : 0;
      t_wm = (reg_wr && reg_waddr == 0) ? 1 : 0;
      t_wr = (reg_wr && reg_waddr == 1) ? 1 : 0;
      t_wc = (reg_wr && reg_waddr == 3) ? 1 : 0;
      t_we = (reg_wr && reg_waddr == 4) ? 1 : 0;
      t_srst = (t_wm == 1 && t_en == 1 && reg_wdata[0] == 1'b0) ? 1 : 0;
      t_nxt = (t_rs == 1 && m_cnt == m_ref) ? 0 : ((m_cnt + 1) % 65536);
      t_match = (t_tick == 1 && t_wc == 0 && t_srst == 0 && t_nxt == m_ref) ? 1 : 0;
      t_cap = (t_en == 1 && ((t_cs == 1 && t_rise == 1) || (t_cs == 2 && t_fall == 1) ||
               (t_cs == 3 && (t_rise == 1 || t_fall == 1)))) ? 1 : 0;
      t_clr = t_we ? int'(reg_wdata[1:0]) : 0;
      // sequential update of the model
      if (t_en == 0) m_pc = 0;
      else if (t_src == 1) m_pc = (m_pc >= t_ps) ? 0 : m_pc + 1;
      m_div = (t_en == 0) ? 0 : (m_div + 1) % 16;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(tmr_in);
      if (t_srst == 1) begin
        m_cap = 0; m_ev = 0; m_out = 1; m_cnt = 0; m_ref = 16'hFFFF;
      end else begin
        if (t_cap == 1) m_cap = m_cnt;
        m_ev = (m_ev & ~t_clr & 3) | (t_match << 1) | t_cap;
        if (t_en == 0) m_out = 1;
        else if (t_match == 1) m_out = (t_tg == 1) ? (1 - m_out) : 0;
        else if (t_tg == 0) m_out = 1;
        if (t_en == 0) m_cnt = 0;
        else if (t_wc == 1) m_cnt = int'(reg_wdata);
        else if (t_tick == 1) m_cnt = t_nxt;
        if (t_wr == 1) m_ref = int'(reg_wdata);
      end
      if (t_wm == 1) m_mode = int'(reg_wdata);
    end
    #(CLK_PERIOD/4);
    if (rst_n && !done) begin
      chk("R3", "tmr_out", int'(tmr_out), m_out);
      chk("R4", "tmr_irq", int'(tmr_irq), model_irq());
      chk(phase, "rdata", int'(reg_rdata), model_read(int'(reg_raddr)));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_LIMIT && !done) begin
      done = 1'b1;
      n_checks++; n_errors++;
      $display("FAIL watchdog: got %0d cycles expected below %0d", cycles, WD_LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  function automatic logic [15:0] mk_mode(input int ps, input int cs, input int tg,
                                          input int ie, input int rs, input int sel, input int en);
    return 16'((ps << 8) | (cs << 6) | (tg << 5) | (ie << 4) | (rs << 3) | (sel << 1) | en);
  endfunction

  task automatic wr_reg(input int a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_waddr = 3'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reg_raddr = 3'((reg_raddr + 1) % 6);
    end
  endtask

  task automatic flip_pin(input int gap);
    @(negedge clk);
    tmr_in = ~tmr_in;
    run(gap);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R8: reset values read through the port
    for (int a = 0; a < 5; a++) begin
      @(negedge clk);
      reg_raddr = 3'(a);
      #1;
      chk("R8", "reset value", int'(reg_rdata), (a == 1) ? 16'hFFFF : 0);
    end
    chk("R8", "reset out", int'(tmr_out), 1);
    chk("R8", "reset irq", int'(tmr_irq), 0);

    phase = "R2"; wr_reg(0, mk_mode(0, 0, 0, 0, 0, 1, 1)); run(30);
    phase = "R1"; wr_reg(0, mk_mode(3, 0, 0, 0, 0, 1, 1)); run(40);
    wr_reg(0, mk_mode(255, 0, 0, 0, 0, 1, 1)); run(600);
    phase = "R2"; wr_reg(0, mk_mode(0, 0, 0, 0, 0, 2, 1)); run(100);
    wr_reg(0, mk_mode(2, 0, 0, 0, 0, 2, 1)); run(150);
    wr_reg(0, mk_mode(2, 0, 0, 0, 0, 0, 1)); run(20);

    phase = "R6"; wr_reg(1, 16'd7); wr_reg(3, 16'd0);
    wr_reg(0, mk_mode(0, 0, 0, 0, 1, 1, 1)); run(60);
    phase = "R3"; wr_reg(0, mk_mode(0, 0, 1, 0, 1, 1, 1)); run(60);
    phase = "R5"; wr_reg(0, mk_mode(0, 0, 1, 0, 0, 1, 1)); run(40);
    phase = "R11"; wr_reg(3, 16'hFFF0); run(40);
    phase = "R5"; wr_reg(1, 16'd0); wr_reg(0, mk_mode(0, 0, 0, 0, 1, 1, 1)); run(12);
    phase = "R3"; wr_reg(1, 16'd5); wr_reg(0, mk_mode(1, 0, 0, 0, 1, 1, 1)); run(30);

    phase = "R4"; wr_reg(0, mk_mode(1, 0, 0, 1, 1, 1, 1)); run(20);
    wr_reg(4, 16'h0003); run(3);

    phase = "R10"; wr_reg(1, 16'd3); wr_reg(0, mk_mode(0, 0, 0, 1, 1, 1, 1));
    for (int k = 0; k < 16; k++) begin
      wr_reg(4, 16'h0002);
      run(k % 3);
    end
    wr_reg(4, 16'h0001); run(4);

    phase = "R9"; wr_reg(1, 16'hFFFF);
    for (int cs = 1; cs < 5; cs++) begin
      wr_reg(0, mk_mode(0, cs % 4, 0, 0, 0, 1, 1));
      for (int t = 0; t < 8; t++) flip_pin(5 + t);
      wr_reg(4, 16'h0003);
    end
    for (int t = 0; t < 6; t++) begin
      @(negedge clk); tmr_in = ~tmr_in;
      wr_reg(3, 16'(t * 100));
    end
    wr_reg(0, mk_mode(0, 3, 0, 0, 0, 1, 1));
    for (int t = 0; t < 6; t++) begin
      @(negedge clk); tmr_in = ~tmr_in;
      wr_reg(4, 16'h0001);
    end

    phase = "R2"; wr_reg(1, 16'd4); wr_reg(0, mk_mode(1, 0, 1, 1, 1, 3, 1));
    for (int t = 0; t < 40; t++) flip_pin(3);

    phase = "R7"; wr_reg(0, mk_mode(0, 3, 0, 1, 0, 1, 0)); run(5);
    wr_reg(1, 16'h1234); wr_reg(3, 16'h0055); run(3);
    for (int t = 0; t < 4; t++) flip_pin(4);
    wr_reg(0, mk_mode(0, 3, 1, 1, 1, 1, 1)); run(30);
    flip_pin(4);
    @(negedge clk); tmr_in = ~tmr_in;
    wr_reg(0, mk_mode(0, 3, 1, 1, 1, 1, 0)); run(6);

    phase = "R5"; wr_reg(1, 16'd2); wr_reg(0, mk_mode(0, 0, 0, 0, 0, 1, 1));
    run(65600);

    phase = "R11"; run(10);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule